// File: doc/BRIEF.md
# OTP Fuse Word Read Controller

This block is the register front end for a one-time-programmable fuse array. Software drives it over a plain 32-bit register bus with an address, a write enable, write data and combinational read data. It holds a control register with set and clear alias addresses, a packed timing register, a data register, a read trigger and a read-result register.

A write of 1 to bit 0 of the trigger register starts a single fuse-word read. The word address comes from the control register. The sequencer raises busy and holds a relax phase of `relax+1` cycles with the strobe low. It then drives the fuse strobe. It ends with a second relax phase of `relax+1` cycles. The whole busy window lasts `strobe_rd+1` cycles.

Some starts are refused: a start while busy, a start with bad timing fields, or a start at an address beyond the fuse array. A refused start sets a sticky error flag. Software clears that flag through the clear alias. Any read that commits while the flag is set stores the poison word 0xBADABADA instead of fuse data.

The fuse interface is a plain strobe with a fixed latency and carries no back-pressure. The array must return the word on `fuse_rdata` in every cycle in which `fuse_strobe` is high. The register bus has no handshake: writes take effect at the clock edge on which `bus_we` is high, and reads reflect current state.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, the following all read as zero: control (0x00), timing (0x10), data (0x20) and read-result (0x40). Busy and error are low.
- R2: A write to control at 0x00 stores three fields: the word address in bits 6:0, a reload request in bit 10 and a 16-bit unlock field in bits 31:16. Error (bit 9) and busy (bit 8) are unaffected. Bits 15:11 and 7 read as zero.
- R3: The alias at 0x04 ORs written 1 bits into address, reload, unlock and error. The alias at 0x08 clears them. Busy (bit 8) ignores both aliases. Both aliases read back the control value.
- R4: Trigger conditions are a 1 in bit 0 of 0x30 and valid timing. The timing fields are relax in bits 15:12 and read strobe S in bits 21:16, with R the relax value. A triggered read raises busy from the next cycle for S+1 cycles. The first R+1 of those cycles have the strobe low. Then `fuse_strobe` is high for S-2R-1 cycles. The strobe cycles present the control address on `fuse_addr`.
- R5: A read that completes with the error flag clear stores the sampled fuse word in the read-result register, in the cycle busy falls.
- R6: A start with relax 0, read strobe 0 or S < 2R+2 is refused. A refused start sets error, never raises busy, and makes read-result 0xBADABADA on the next cycle. A start with S = 2R+2 is accepted.
- R7: A start while busy sets error. The running read still takes its full length and commits 0xBADABADA.
- R8: A start at an address at or above the FUSE_WORDS parameter is refused as in R6. The highest valid address reads normally.
- R9: Error is sticky until a 1 is written to bit 9 at 0x08. A read that completes while error is set commits 0xBADABADA.
- R10: An accepted read clears the unlock field to zero.
- R11: Timing reads back its low 22 bits with the upper bits zero. Data reads back 32 bits. The trigger register reads zero. Unmapped addresses read zero and ignore writes.
- R12: A write to 0x30 with bit 0 clear starts nothing and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | BUS_AW | Register byte address |
| bus_we | input | 1 | Write enable, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| fuse_addr | output | 7 | Word address presented to the fuse array |
| fuse_strobe | output | 1 | Fuse read strobe |
| fuse_rdata | input | 32 | Fuse word returned during strobe |

## Verification
The bench counts busy, pre-strobe and strobe cycles for several timing pairs. This includes the tightest accepted case S = 2R+2, where an off-by-one in a phase counter would lose or add the single strobe cycle. It drives refused starts for each cause: zero fields, S one short of the minimum, and the first address past the array. A controller that let one through would raise busy or return real fuse data where poison is required. It issues a second trigger during a running read and lets a read finish over a pre-set error flag, which catches a design that aborts the read or commits good data. It also checks that the unlock field clears, that busy ignores the aliases, and that unmapped writes leave all state alone.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int DW = 32;
  localparam int FA_W = 7;
  localparam int RLX_W = 4;
  localparam int STB_W = 6;
  localparam int TIM_W = 22;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_SET  = 8'h04;
  localparam logic [7:0] OFS_CLR  = 8'h08;
  localparam logic [7:0] OFS_TIME = 8'h10;
  localparam logic [7:0] OFS_DATA = 8'h20;
  localparam logic [7:0] OFS_TRIG = 8'h30;
  localparam logic [7:0] OFS_RDAT = 8'h40;

  localparam int B_BUSY   = 8;
  localparam int B_ERR    = 9;
  localparam int B_RELOAD = 10;
  localparam int B_UNLOCK = 16;
  localparam int B_RELAX  = 12;
  localparam int B_STROBE = 16;

  localparam logic [DW-1:0] POISON = 32'hBADA_BADA;

  typedef enum logic [1:0] {SQ_IDLE, SQ_PRE, SQ_ACT, SQ_POST} seq_state_e;
endpackage

// File: rtl/otp_seq.sv
module otp_seq
  import otp_pkg::*;
#(
  parameter int FUSE_WORDS = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [FA_W-1:0]  addr,
  input  logic [RLX_W-1:0] relax,
  input  logic [STB_W-1:0] strobe,
  input  logic [DW-1:0]    fuse_rdata,
  output logic             busy,
  output logic             accept,
  output logic             reject,
  output logic             done,
  output logic [DW-1:0]    result,
  output logic [FA_W-1:0]  fuse_addr,
  output logic             fuse_strobe
);
  seq_state_e       state_q;
  logic [STB_W-1:0] cnt_q;
  logic [STB_W-1:0] rlx_q;
  logic [STB_W-1:0] act_m1_q;
  logic [FA_W-1:0]  addr_q;
  logic [DW-1:0]    cap_q;
  logic [STB_W:0]   need;
  logic             timing_ok;
  logic             range_ok;

  assign need      = ((STB_W+1)'(relax) << 1) + (STB_W+1)'(2);
  assign timing_ok = (relax != '0) && (strobe != '0) && ({1'b0, strobe} >= need);
  assign range_ok  = {1'b0, addr} < (FA_W+1)'(FUSE_WORDS);

  assign busy        = (state_q != SQ_IDLE);
  assign reject      = start && (busy || !timing_ok || !range_ok);
  assign accept      = start && !reject;
  assign done        = (state_q == SQ_POST) && (cnt_q == '0);
  assign fuse_strobe = (state_q == SQ_ACT);
  assign fuse_addr   = addr_q;
  assign result      = cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      cnt_q    <= '0;
      rlx_q    <= '0;
      act_m1_q <= '0;
      addr_q   <= '0;
      cap_q    <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (accept) begin
          state_q  <= SQ_PRE;
          cnt_q    <= STB_W'(relax);
          rlx_q    <= STB_W'(relax);
          act_m1_q <= strobe - STB_W'(need);
          addr_q   <= addr;
        end
        SQ_PRE: begin
          if (cnt_q == '0) begin
            state_q <= SQ_ACT;
            cnt_q   <= act_m1_q;
          end else cnt_q <= cnt_q - 1'b1;
        end
        SQ_ACT: begin
          cap_q <= fuse_rdata;
          if (cnt_q == '0) begin
            state_q <= SQ_POST;
            cnt_q   <= rlx_q;
          end else cnt_q <= cnt_q - 1'b1;
        end
        SQ_POST: begin
          if (cnt_q == '0) state_q <= SQ_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/otp_regs.sv
module otp_regs
  import otp_pkg::*;
#(
  parameter int BUS_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              busy,
  input  logic              accept,
  input  logic              reject,
  input  logic              done,
  input  logic [DW-1:0]     result,
  output logic              start,
  output logic              err,
  output logic [FA_W-1:0]   ctrl_addr,
  output logic [RLX_W-1:0]  relax,
  output logic [STB_W-1:0]  strobe
);
  logic [FA_W-1:0]  addr_q;
  logic             reload_q;
  logic [15:0]      unlock_q;
  logic             err_q;
  logic             err_d;
  logic [TIM_W-1:0] timing_q;
  logic [DW-1:0]    data_q;
  logic [DW-1:0]    rdat_q;
  logic [DW-1:0]    ctrl_word;
  logic we_ctrl, we_set, we_clr, we_time, we_data;

  assign we_ctrl = bus_we && (bus_addr == BUS_AW'(OFS_CTRL));
  assign we_set  = bus_we && (bus_addr == BUS_AW'(OFS_SET));
  assign we_clr  = bus_we && (bus_addr == BUS_AW'(OFS_CLR));
  assign we_time = bus_we && (bus_addr == BUS_AW'(OFS_TIME));
  assign we_data = bus_we && (bus_addr == BUS_AW'(OFS_DATA));
  assign start   = bus_we && (bus_addr == BUS_AW'(OFS_TRIG)) && bus_wdata[0];

  assign ctrl_addr = addr_q;
  assign relax     = timing_q[B_RELAX +: RLX_W];
  assign strobe    = timing_q[B_STROBE +: STB_W];
  assign err       = err_q;

  always_comb begin
    err_d = err_q;
    if (we_set && bus_wdata[B_ERR]) err_d = 1'b1;
    if (we_clr && bus_wdata[B_ERR]) err_d = 1'b0;
    if (reject) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      reload_q <= 1'b0;
      unlock_q <= '0;
      err_q    <= 1'b0;
      timing_q <= '0;
      data_q   <= '0;
      rdat_q   <= '0;
    end else begin
      err_q <= err_d;
      if (we_ctrl) begin
        addr_q   <= bus_wdata[FA_W-1:0];
        reload_q <= bus_wdata[B_RELOAD];
        unlock_q <= bus_wdata[B_UNLOCK +: 16];
      end else if (we_set) begin
        addr_q   <= addr_q | bus_wdata[FA_W-1:0];
        reload_q <= reload_q | bus_wdata[B_RELOAD];
        unlock_q <= unlock_q | bus_wdata[B_UNLOCK +: 16];
      end else if (we_clr) begin
        addr_q   <= addr_q & ~bus_wdata[FA_W-1:0];
        reload_q <= reload_q & ~bus_wdata[B_RELOAD];
        unlock_q <= unlock_q & ~bus_wdata[B_UNLOCK +: 16];
      end else if (accept) begin
        unlock_q <= '0;
      end
      if (we_time) timing_q <= bus_wdata[TIM_W-1:0];
      if (we_data) data_q <= bus_wdata;
      if (done || (reject && !busy)) rdat_q <= err_d ? POISON : result;
    end
  end

  assign ctrl_word = {unlock_q, 5'b0, reload_q, err_q, busy, 1'b0, addr_q};

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == BUS_AW'(OFS_CTRL) || bus_addr == BUS_AW'(OFS_SET) ||
        bus_addr == BUS_AW'(OFS_CLR))        bus_rdata = ctrl_word;
    else if (bus_addr == BUS_AW'(OFS_TIME)) bus_rdata = DW'(timing_q);
    else if (bus_addr == BUS_AW'(OFS_DATA)) bus_rdata = data_q;
    else if (bus_addr == BUS_AW'(OFS_RDAT)) bus_rdata = rdat_q;
  end
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_pkg::*;
#(
  parameter int BUS_AW     = 8,
  parameter int FUSE_WORDS = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [6:0]        fuse_addr,
  output logic              fuse_strobe,
  input  logic [31:0]       fuse_rdata
);
  logic             start, busy, accept, reject, done, err;
  logic [DW-1:0]    result;
  logic [FA_W-1:0]  ctrl_addr;
  logic [RLX_W-1:0] relax;
  logic [STB_W-1:0] strobe;

  otp_regs #(.BUS_AW(BUS_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .accept(accept), .reject(reject), .done(done), .result(result),
    .start(start), .err(err), .ctrl_addr(ctrl_addr), .relax(relax),
    .strobe(strobe)
  );

  otp_seq #(.FUSE_WORDS(FUSE_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(ctrl_addr),
    .relax(relax), .strobe(strobe), .fuse_rdata(fuse_rdata),
    .busy(busy), .accept(accept), .reject(reject), .done(done),
    .result(result), .fuse_addr(fuse_addr), .fuse_strobe(fuse_strobe)
  );
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk #(
  parameter int BUS_AW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_we,
  input logic              err_wbit,
  input logic              busy,
  input logic              err,
  input logic              reject,
  input logic              done,
  input logic              start,
  input logic              fuse_strobe,
  input logic [6:0]        fuse_addr
);
  logic clr_err;
  assign clr_err = bus_we && (bus_addr == BUS_AW'(8'h08)) && err_wbit;

  assert_strobe_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_strobe |-> busy);

  assert_addr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(fuse_addr));

  assert_reject_sets_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> err);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err && !clr_err |=> err);

  assert_busy_needs_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> !busy);

  assert_inflight_survives_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reject && busy && !done |=> busy);
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(.BUS_AW(BUS_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .err_wbit(bus_wdata[9]), .busy(busy), .err(err), .reject(reject),
  .done(done), .start(start), .fuse_strobe(fuse_strobe), .fuse_addr(fuse_addr)
);

// File: tb/otp_fuse_ctrl_test.sv
module otp_fuse_ctrl_test;
  localparam int CLK_NS = 10;
  localparam int FUSE_N = 96;
  localparam logic [31:0] POIS = 32'hBADA_BADA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  fuse_addr;
  logic        fuse_strobe;
  logic [31:0] fuse_rdata;
  logic [31:0] fuse_mem [128];

  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  initial for (int i = 0; i < 128; i++)
    fuse_mem[i] = {8'(i), 8'(~i), 8'(i * 3), 8'h5A};

  assign fuse_rdata = fuse_strobe ? fuse_mem[fuse_addr] : 32'h0;

  otp_fuse_ctrl #(.BUS_AW(8), .FUSE_WORDS(FUSE_N)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fuse_addr(fuse_addr),
    .fuse_strobe(fuse_strobe), .fuse_rdata(fuse_rdata)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(bus_rdata === e.v, e.tag, bus_rdata, e.v);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_t x;
    @(posedge clk); #1;
    bus_we = 1'b0; bus_addr = a;
    x.v = e; x.tag = tag;
    exp_q.push_back(x);
  endtask

  task automatic run_read(input int exp_busy, input int exp_pre, input int exp_act,
                          input string tag);
    int nb = 0, np = 0, na = 0;
    wr(8'h30, 32'h1);
    @(posedge clk); #1;
    bus_we = 1'b0; bus_addr = 8'h00;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (bus_rdata[8]) nb++;
      if (fuse_strobe) na++;
      if (bus_rdata[8] && !fuse_strobe && na == 0) np++;
    end
    check(nb == exp_busy, {tag, " busy cycles"}, 32'(nb), 32'(exp_busy));
    check(np == exp_pre,  {tag, " pre-relax cycles"}, 32'(np), 32'(exp_pre));
    check(na == exp_act,  {tag, " strobe cycles"}, 32'(na), 32'(exp_act));
  endtask

  task automatic drain;
    repeat (3) @(posedge clk);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(8'h00, 32'h0, "R1 control");
    rd(8'h10, 32'h0, "R1 timing");
    rd(8'h20, 32'h0, "R1 data");
    rd(8'h40, 32'h0, "R1 read-result");
    // R11 unmapped address
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, 32'h0, "R11 unmapped read");
    rd(8'h10, 32'h0, "R11 unmapped write ignored");
    // R12 trigger with bit 0 clear
    wr(8'h30, 32'hFFFF_FFFE);
    rd(8'h00, 32'h0, "R12 no start");
    rd(8'h30, 32'h0, "R11 trigger reads zero");
    rd(8'h40, 32'h0, "R12 result untouched");
    // R2 plain control write
    wr(8'h00, 32'h3E77_FFFF);
    rd(8'h00, 32'h3E77_047F, "R2 control fields");
    // R3 aliases
    wr(8'h08, 32'h0000_0400);
    rd(8'h08, 32'h3E77_007F, "R3 clear reload");
    wr(8'h04, 32'h0000_0300);
    rd(8'h04, 32'h3E77_027F, "R3 set err, busy ignored");
    wr(8'h08, 32'h0000_0300);
    rd(8'h00, 32'h3E77_007F, "R9 clear err");
    // R11 timing and data
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'h003F_FFFF, "R11 timing width");
    wr(8'h20, 32'h1234_5678);
    rd(8'h20, 32'h1234_5678, "R11 data");
    // R4 R5 R10 normal read, relax 2 strobe 10
    wr(8'h00, 32'h3E77_0005);
    wr(8'h10, 32'h000A_2000);
    run_read(11, 3, 5, "R4 r2s10");
    rd(8'h40, fuse_mem[5], "R5 fuse word 5");
    rd(8'h00, 32'h0000_0005, "R10 unlock cleared");
    // R8 last valid address, relax 1 strobe 4
    wr(8'h00, 32'h0000_005F);
    wr(8'h10, 32'h0004_1000);
    run_read(5, 2, 1, "R4 r1s4");
    rd(8'h40, fuse_mem[95], "R8 last valid word");
    // R6 boundary S = 2R+2
    wr(8'h00, 32'h0000_0003);
    wr(8'h10, 32'h0006_2000);
    run_read(7, 3, 1, "R6 boundary");
    rd(8'h40, fuse_mem[3], "R6 boundary data");
    // R6 relax zero
    wr(8'h10, 32'h000A_0000);
    wr(8'h30, 32'h1);
    rd(8'h00, 32'h0000_0203, "R6 relax0 err no busy");
    rd(8'h40, POIS, "R6 relax0 poison");
    wr(8'h08, 32'h0000_0200);
    // R6 strobe one short
    wr(8'h10, 32'h0005_2000);
    wr(8'h30, 32'h1);
    rd(8'h00, 32'h0000_0203, "R6 short strobe err");
    wr(8'h08, 32'h0000_0200);
    // R6 strobe zero
    wr(8'h10, 32'h0000_2000);
    wr(8'h30, 32'h1);
    rd(8'h00, 32'h0000_0203, "R6 strobe0 err");
    wr(8'h08, 32'h0000_0200);
    // R8 out of range
    wr(8'h00, 32'h0000_0060);
    wr(8'h10, 32'h0006_2000);
    wr(8'h30, 32'h1);
    rd(8'h00, 32'h0000_0260, "R8 out of range err");
    rd(8'h40, POIS, "R8 poison");
    wr(8'h08, 32'h0000_0200);
    // R9 read finishing over sticky err
    wr(8'h00, 32'h0000_0003);
    wr(8'h04, 32'h0000_0200);
    run_read(7, 3, 1, "R9 sticky");
    rd(8'h40, POIS, "R9 poison over err");
    rd(8'h00, 32'h0000_0203, "R9 err still set");
    wr(8'h08, 32'h0000_0200);
    // R7 trigger while busy
    wr(8'h00, 32'h0000_0005);
    wr(8'h10, 32'h000A_2000);
    wr(8'h30, 32'h1);
    wr(8'h30, 32'h1);
    rd(8'h00, 32'h0000_0305, "R7 err and still busy");
    repeat (20) @(posedge clk);
    rd(8'h00, 32'h0000_0205, "R7 done with err");
    rd(8'h40, POIS, "R7 poison");
    drain();
    summary();
  end
endmodule